// File: doc/BRIEF.md
# PLL Setting Search Engine

This block finds the settings of a three-field PLL whose output comes as close as possible to a requested frequency without going above it. The PLL output is the parent frequency times (m+1), divided by (d1+1)·2^d2. Here m is an 8-bit multiplier, d1 a 1-bit pre-divider and d2 a 3-bit power-of-two post-divider. Every quotient is truncated to an integer.

A single start pulse captures three inputs: the parent frequency in Hz, the same frequency in whole MHz, and the target in Hz. The engine then tries one candidate per clock in a fixed order and keeps the best undershooting candidate. It stops early on an exact hit. When it finishes, it presents a set of registered results together with a one-cycle done pulse:

- the chosen fields;
- a loop-filter code derived from the pre-divided reference in MHz;
- a flag for a reference outside the recommended band;
- a packed 32-bit configuration word;
- the achieved frequency;
- a flag for the case where no candidate fits.

Because (d1+1)·2^d2 is always a power of two, each candidate needs only one multiply and one right shift. The MHz input lets the filter decision be made without a divider.

Top module: `pll_cfg_search`

## Requirements
- R1: The achieved frequency of a candidate equals floor(parent·(m+1) / ((d1+1)·2^d2)), with m in 0..255, d1 in 0..1 and d2 in 0..7.
- R2: Candidates are visited in a fixed order: d1 from 1 down to 0, then d2 from 7 down to 0, with m rising from 0 to 255 innermost. Among candidates with equal error, the first one visited is reported.
- R3: Only candidates whose frequency does not exceed the target are accepted. The reported candidate has the smallest error among them.
- R4: A candidate with zero error ends the search at once. If the first candidate is exact, done rises no later than 4 clock cycles after the cycle in which start is sampled.
- R5: If no candidate is at or below the target, no_fit is 1. In that case mul_o, pre_o, post_o, filt_o, band_warn, cfg_word and ach_hz are all 0.
- R6: filt_o is derived from f = parent_mhz / (d1+1), integer, using the reported d1. It is 7 for f≥166, 6 for f≥104, 5 for f≥65, 4 for f≥42, 3 for f≥26, 2 for f≥16, 1 for f≥10, and 0 otherwise.
- R7: band_warn is 1 when f (as in R6) is below 10 or above 200, and 0 otherwise.
- R8: cfg_word carries filt_o in bits 31..24, m in bits 23..16, d1 in bit 8 and d2 in bits 2..0. Every other bit is 0.
- R9: done is a one-cycle pulse. All result outputs hold their values until the next done.
- R10: A start pulse that arrives while a search is running has no effect on that search or on its results.
- R11: After reset, done, no_fit, band_warn and every result output are 0.
- R12: A search with no exact hit visits all 4096 candidates, so done comes no earlier than 4096 cycles after start is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request; sampled only when idle |
| parent_hz | input | 32 | Parent frequency in Hz |
| parent_mhz | input | 12 | Parent frequency in whole MHz, used for the filter choice |
| target_hz | input | 32 | Requested output frequency in Hz |
| done | output | 1 | One-cycle pulse when results are valid |
| no_fit | output | 1 | No candidate at or below the target |
| band_warn | output | 1 | Pre-divided reference outside 10..200 MHz |
| mul_o | output | 8 | Chosen multiplier field m |
| pre_o | output | 1 | Chosen pre-divider field d1 |
| post_o | output | 3 | Chosen post-divider exponent d2 |
| filt_o | output | 3 | Loop-filter code |
| cfg_word | output | 32 | Packed configuration word |
| ach_hz | output | 32 | Achieved output frequency in Hz |

## Verification
The assertions assume several things about the inputs:

- parent_hz·256 fits the internal product width.
- The inputs presented with start describe one request.
- parent_mhz agrees with parent_hz, because the filter and band checks compare codes against the reported d1 and never recompute MHz from Hz.

The stimulus keeps to these assumptions. Every vector gives parent_mhz as the truncated parent_hz/10^6 and changes the inputs only at a start pulse. The exception is the deliberate mid-search start pulse, whose inputs must be ignored.

// File: rtl/pll_search_pkg.sv
package pll_search_pkg;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_RUN  = 2'd1,
    S_FIN  = 2'd2
  } srch_state_t;

  localparam int FILT_W   = 3;
  localparam int CFG_W    = 32;
  localparam int FILT_LSB = 24;
  localparam int FILT_FW  = 8;
  localparam int MUL_LSB  = 16;
  localparam int PRE_BIT  = 8;
  localparam int POST_LSB = 0;

  localparam int BAND_LO = 10;
  localparam int BAND_HI = 200;

endpackage

// File: rtl/pll_cand_seq.sv
module pll_cand_seq #(
  parameter int MUL_W = 8,
  parameter int D2_W  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             step,
  output logic [MUL_W-1:0] m,
  output logic             d1,
  output logic [D2_W-1:0]  d2,
  output logic             last
);

  logic m_wrap;
  logic d2_wrap;

  assign m_wrap  = (m == {MUL_W{1'b1}});
  assign d2_wrap = (d2 == '0);
  assign last    = m_wrap && d2_wrap && !d1;

  always_ff @(posedge clk) begin
    if (rst) begin
      m  <= '0;
      d1 <= 1'b1;
      d2 <= {D2_W{1'b1}};
    end else if (load) begin
      m  <= '0;
      d1 <= 1'b1;
      d2 <= {D2_W{1'b1}};
    end else if (step) begin
      m <= m + 1'b1;
      if (m_wrap) begin
        if (d2_wrap) begin
          d2 <= {D2_W{1'b1}};
          d1 <= 1'b0;
        end else begin
          d2 <= d2 - 1'b1;
        end
      end
    end
  end

  // R2: the post-divider only moves downward while the pre-divider holds
  a_r2_post_descends: assert property (@(posedge clk) disable iff (rst)
    (step && !load && m_wrap && !d2_wrap) |=> (d2 < $past(d2)));

endmodule

// File: rtl/pll_cand_eval.sv
module pll_cand_eval #(
  parameter int PAR_W = 32,
  parameter int TGT_W = 32,
  parameter int MUL_W = 8,
  parameter int D2_W  = 3
) (
  input  logic [PAR_W-1:0] par,
  input  logic [TGT_W-1:0] tgt,
  input  logic [MUL_W-1:0] m,
  input  logic             d1,
  input  logic [D2_W-1:0]  d2,
  output logic             fits,
  output logic             exact,
  output logic [TGT_W-1:0] err,
  output logic [TGT_W-1:0] freq
);

  localparam int MP1_W = MUL_W + 1;
  localparam int PRD_W = PAR_W + MP1_W;
  localparam int SH_W  = D2_W + 1;

  logic [MP1_W-1:0] mp1;
  logic [PRD_W-1:0] prod;
  logic [PRD_W-1:0] shifted;
  logic [SH_W-1:0]  sh;

  assign mp1     = {1'b0, m} + MP1_W'(1);
  assign prod    = PRD_W'(par) * PRD_W'(mp1);
  assign sh      = {1'b0, d2} + SH_W'(d1);
  assign shifted = prod >> sh;
  assign fits    = (shifted <= PRD_W'(tgt));
  assign freq    = shifted[TGT_W-1:0];
  assign err     = tgt - freq;
  assign exact   = fits && (err == '0);

endmodule

// File: rtl/pll_best_track.sv
module pll_best_track #(
  parameter int TGT_W = 32,
  parameter int MUL_W = 8,
  parameter int D2_W  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             valid,
  input  logic             fits,
  input  logic [TGT_W-1:0] err,
  input  logic [TGT_W-1:0] freq,
  input  logic [MUL_W-1:0] m,
  input  logic             d1,
  input  logic [D2_W-1:0]  d2,
  output logic             found,
  output logic [TGT_W-1:0] best_err,
  output logic [TGT_W-1:0] best_freq,
  output logic [MUL_W-1:0] best_m,
  output logic             best_d1,
  output logic [D2_W-1:0]  best_d2
);

  logic take;

  assign take = valid && fits && (!found || (err < best_err));

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      found     <= 1'b0;
      best_err  <= '0;
      best_freq <= '0;
      best_m    <= '0;
      best_d1   <= 1'b0;
      best_d2   <= '0;
    end else if (take) begin
      found     <= 1'b1;
      best_err  <= err;
      best_freq <= freq;
      best_m    <= m;
      best_d1   <= d1;
      best_d2   <= d2;
    end
  end

  // R3: once a fit exists, the stored error never grows within a search
  a_r3_err_shrinks: assert property (@(posedge clk) disable iff (rst)
    ($past(found) && found) |-> (best_err <= $past(best_err)));

endmodule

// File: rtl/pll_filter_sel.sv
module pll_filter_sel
  import pll_search_pkg::*;
#(
  parameter int MHZ_W = 12
) (
  input  logic [MHZ_W-1:0]  mhz,
  input  logic              d1,
  output logic [FILT_W-1:0] code,
  output logic              warn
);

  logic [MHZ_W-1:0] f;

  assign f = mhz >> d1;

  always_comb begin
    if      (f >= MHZ_W'(166)) code = 3'd7;
    else if (f >= MHZ_W'(104)) code = 3'd6;
    else if (f >= MHZ_W'(65))  code = 3'd5;
    else if (f >= MHZ_W'(42))  code = 3'd4;
    else if (f >= MHZ_W'(26))  code = 3'd3;
    else if (f >= MHZ_W'(16))  code = 3'd2;
    else if (f >= MHZ_W'(10))  code = 3'd1;
    else                       code = 3'd0;
  end

  assign warn = (f < MHZ_W'(BAND_LO)) || (f > MHZ_W'(BAND_HI));

endmodule

// File: rtl/pll_cfg_search.sv
module pll_cfg_search
  import pll_search_pkg::*;
#(
  parameter int PAR_W = 32,
  parameter int TGT_W = 32,
  parameter int MHZ_W = 12,
  parameter int MUL_W = 8,
  parameter int D2_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [PAR_W-1:0]  parent_hz,
  input  logic [MHZ_W-1:0]  parent_mhz,
  input  logic [TGT_W-1:0]  target_hz,
  output logic              done,
  output logic              no_fit,
  output logic              band_warn,
  output logic [MUL_W-1:0]  mul_o,
  output logic              pre_o,
  output logic [D2_W-1:0]   post_o,
  output logic [FILT_W-1:0] filt_o,
  output logic [CFG_W-1:0]  cfg_word,
  output logic [TGT_W-1:0]  ach_hz
);

  srch_state_t state_q;

  logic [PAR_W-1:0] par_q;
  logic [TGT_W-1:0] tgt_q;
  logic [MHZ_W-1:0] mhz_q;

  logic             seq_load;
  logic             seq_step;
  logic [MUL_W-1:0] c_m;
  logic             c_d1;
  logic [D2_W-1:0]  c_d2;
  logic             c_last;

  logic             c_fits;
  logic             c_exact;
  logic [TGT_W-1:0] c_err;
  logic [TGT_W-1:0] c_freq;

  logic             b_found;
  logic [TGT_W-1:0] b_err;
  logic [TGT_W-1:0] b_freq;
  logic [MUL_W-1:0] b_m;
  logic             b_d1;
  logic [D2_W-1:0]  b_d2;

  logic [FILT_W-1:0] f_code;
  logic              f_warn;
  logic [CFG_W-1:0]  packed_w;

  logic running;
  logic finish;

  assign running  = (state_q == S_RUN);
  assign finish   = running && (c_exact || c_last);
  assign seq_load = (state_q == S_IDLE) && start;
  assign seq_step = running && !finish;

  pll_cand_seq #(.MUL_W(MUL_W), .D2_W(D2_W)) u_seq (
    .clk  (clk),
    .rst  (rst),
    .load (seq_load),
    .step (seq_step),
    .m    (c_m),
    .d1   (c_d1),
    .d2   (c_d2),
    .last (c_last)
  );

  pll_cand_eval #(.PAR_W(PAR_W), .TGT_W(TGT_W), .MUL_W(MUL_W), .D2_W(D2_W)) u_eval (
    .par   (par_q),
    .tgt   (tgt_q),
    .m     (c_m),
    .d1    (c_d1),
    .d2    (c_d2),
    .fits  (c_fits),
    .exact (c_exact),
    .err   (c_err),
    .freq  (c_freq)
  );

  pll_best_track #(.TGT_W(TGT_W), .MUL_W(MUL_W), .D2_W(D2_W)) u_best (
    .clk       (clk),
    .rst       (rst),
    .clear     (seq_load),
    .valid     (running),
    .fits      (c_fits),
    .err       (c_err),
    .freq      (c_freq),
    .m         (c_m),
    .d1        (c_d1),
    .d2        (c_d2),
    .found     (b_found),
    .best_err  (b_err),
    .best_freq (b_freq),
    .best_m    (b_m),
    .best_d1   (b_d1),
    .best_d2   (b_d2)
  );

  pll_filter_sel #(.MHZ_W(MHZ_W)) u_filt (
    .mhz  (mhz_q),
    .d1   (b_d1),
    .code (f_code),
    .warn (f_warn)
  );

  always_comb begin
    packed_w = '0;
    packed_w[FILT_LSB +: FILT_FW] = FILT_FW'(f_code);
    packed_w[MUL_LSB +: MUL_W]    = b_m;
    packed_w[PRE_BIT]             = b_d1;
    packed_w[POST_LSB +: D2_W]    = b_d2;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
      par_q   <= '0;
      tgt_q   <= '0;
      mhz_q   <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (start) begin
          par_q   <= parent_hz;
          tgt_q   <= target_hz;
          mhz_q   <= parent_mhz;
          state_q <= S_RUN;
        end
        S_RUN:   if (finish) state_q <= S_FIN;
        S_FIN:   state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done      <= 1'b0;
      no_fit    <= 1'b0;
      band_warn <= 1'b0;
      mul_o     <= '0;
      pre_o     <= 1'b0;
      post_o    <= '0;
      filt_o    <= '0;
      cfg_word  <= '0;
      ach_hz    <= '0;
    end else begin
      done <= 1'b0;
      if (state_q == S_FIN) begin
        done   <= 1'b1;
        no_fit <= !b_found;
        if (b_found) begin
          band_warn <= f_warn;
          mul_o     <= b_m;
          pre_o     <= b_d1;
          post_o    <= b_d2;
          filt_o    <= f_code;
          cfg_word  <= packed_w;
          ach_hz    <= b_freq;
        end else begin
          band_warn <= 1'b0;
          mul_o     <= '0;
          pre_o     <= 1'b0;
          post_o    <= '0;
          filt_o    <= '0;
          cfg_word  <= '0;
          ach_hz    <= '0;
        end
      end
    end
  end

  // R9: done never stays high for two cycles
  a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R5: an empty result carries only zeros
  a_r5_nofit_zero: assert property (@(posedge clk) disable iff (rst)
    (done && no_fit) |-> (cfg_word == '0 && ach_hz == '0 && mul_o == '0 && !band_warn));

  // R3: a reported frequency never exceeds the captured target
  a_r3_undershoot: assert property (@(posedge clk) disable iff (rst)
    (done && !no_fit) |-> (ach_hz <= tgt_q));

  // R7: a band warning only occurs at the extreme filter codes
  a_r7_warn_code: assert property (@(posedge clk) disable iff (rst)
    (done && band_warn) |-> (filt_o == 3'd0 || filt_o == 3'd7));

  // R4: an exact hit leads straight to the result cycle
  a_r4_exact_stop: assert property (@(posedge clk) disable iff (rst)
    (running && c_exact) |=> (state_q == S_FIN && b_err == '0));

endmodule

// File: tb/pll_cfg_search_bench.sv
`timescale 1ns/1ps
module pll_cfg_search_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] parent_hz = '0;
  logic [11:0] parent_mhz = '0;
  logic [31:0] target_hz = '0;
  logic        done, no_fit, band_warn, pre_o;
  logic [7:0]  mul_o;
  logic [2:0]  post_o, filt_o;
  logic [31:0] cfg_word, ach_hz;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  pll_cfg_search u_pll_cfg_search (
    .clk(clk), .rst(rst), .start(start),
    .parent_hz(parent_hz), .parent_mhz(parent_mhz), .target_hz(target_hz),
    .done(done), .no_fit(no_fit), .band_warn(band_warn),
    .mul_o(mul_o), .pre_o(pre_o), .post_o(post_o), .filt_o(filt_o),
    .cfg_word(cfg_word), .ach_hz(ach_hz)
  );

  typedef struct packed {
    logic [31:0] par;
    logic [11:0] mhz;
    logic [31:0] tgt;
    logic        nofit;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{32'd25000000,  12'd25,  32'd600000000,  1'b0},
    '{32'd24000000,  12'd24,  32'd1000000000, 1'b0},
    '{32'd27000000,  12'd27,  32'd123456789,  1'b0},
    '{32'd100000000, 12'd100, 32'd300000000,  1'b0},
    '{32'd200000000, 12'd200, 32'd1500000000, 1'b0},
    '{32'd400000000, 12'd400, 32'd99999999,   1'b0},
    '{32'd12000000,  12'd12,  32'd50000,      1'b0},
    '{32'd25600000,  12'd25,  32'd99999,      1'b1},
    '{32'd180000000, 12'd180, 32'd777777777,  1'b0},
    '{32'd50000000,  12'd50,  32'd3000000000, 1'b0}
  };

  task automatic chk(input string tag, input longint unsigned act, input longint unsigned exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Search model written from the requirements (R1, R2, R3)
  function automatic void ref_search(input longint unsigned par, input longint unsigned tgt,
      output bit fnd, output int bm, output int bd1, output int bd2, output longint unsigned bach);
    longint unsigned best_e = 0;
    fnd = 0; bm = 0; bd1 = 0; bd2 = 0; bach = 0;
    for (int a = 1; a >= 0; a--)
      for (int b = 7; b >= 0; b--)
        for (int c = 0; c < 256; c++) begin
          longint unsigned t;
          longint unsigned e;
          t = (par * longint'(c + 1)) / longint'((a + 1) * (1 << b));
          if (t <= tgt) begin
            e = tgt - t;
            if (!fnd || e < best_e) begin
              fnd = 1; best_e = e; bm = c; bd1 = a; bd2 = b; bach = t;
            end
            if (e == 0) return;
          end
        end
  endfunction

  function automatic int ref_filt(input int mhz, input int d1);
    int f = mhz / (d1 + 1);
    if (f >= 166) return 7;
    if (f >= 104) return 6;
    if (f >= 65)  return 5;
    if (f >= 42)  return 4;
    if (f >= 26)  return 3;
    if (f >= 16)  return 2;
    if (f >= 10)  return 1;
    return 0;
  endfunction

  task automatic kick(input logic [31:0] p, input logic [11:0] mz, input logic [31:0] t);
    @(negedge clk);
    parent_hz = p; parent_mhz = mz; target_hz = t; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output int lat);
    lat = 1;
    while (!done) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic check_result(input string tag, input longint unsigned p, input int mz,
                              input longint unsigned t);
    bit fnd; int bm, bd1, bd2; longint unsigned bach;
    int fc, fr; bit wn; longint unsigned w;
    ref_search(p, t, fnd, bm, bd1, bd2, bach);
    chk({tag, " R5 no_fit"}, no_fit, !fnd);
    if (fnd) begin
      fc = ref_filt(mz, bd1);
      fr = mz / (bd1 + 1);
      wn = (fr < 10) || (fr > 200);
      w  = (longint'(fc) << 24) | (longint'(bm) << 16) | (longint'(bd1) << 8) | longint'(bd2);
      chk({tag, " R1 ach_hz"}, ach_hz, bach);
      chk({tag, " R2 R3 fields"}, {mul_o, pre_o, post_o}, {bm[7:0], bd1[0], bd2[2:0]});
      chk({tag, " R6 filt_o"}, filt_o, fc);
      chk({tag, " R7 band_warn"}, band_warn, wn);
      chk({tag, " R8 cfg_word"}, cfg_word, w);
    end else begin
      chk({tag, " R5 zero outputs"}, {cfg_word, ach_hz, mul_o, pre_o, post_o, filt_o, band_warn}, 0);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int lat;
    logic [31:0] held;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11: reset state
    chk("R11 reset outputs", {done, no_fit, band_warn, cfg_word, ach_hz, mul_o, filt_o}, 0);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      kick(VECS[i].par, VECS[i].mhz, VECS[i].tgt);
      wait_done(lat);
      chk($sformatf("R5 vec%0d no_fit", i), no_fit, VECS[i].nofit);
      check_result($sformatf("vec%0d", i), VECS[i].par, VECS[i].mhz, VECS[i].tgt);
    end

    // R4: first candidate exact -> early exit
    kick(32'd25600000, 12'd25, 32'd100000);
    wait_done(lat);
    chk("R4 early latency", lat <= 4, 1);
    chk("R4 exact fields", {mul_o, pre_o, post_o}, {8'd0, 1'b1, 3'd7});
    chk("R4 exact ach", ach_hz, 100000);

    // R1: truncation on an odd parent
    kick(32'd1000003, 12'd1, 32'd3906);
    wait_done(lat);
    chk("R1 truncated ach", ach_hz, 3906);
    chk("R7 low band warn", band_warn, 1);

    // R2 tie, R12 full sweep, R9 pulse and hold
    kick(32'd25600000, 12'd25, 32'd200001);
    wait_done(lat);
    chk("R12 full sweep latency", lat >= 4096, 1);
    chk("R2 tie earliest fields", {mul_o, pre_o, post_o}, {8'd1, 1'b1, 3'd7});
    chk("R8 tie word", cfg_word, 32'h01010107);
    chk("R6 tie filt", filt_o, 1);
    held = cfg_word;
    @(negedge clk);
    chk("R9 done pulse width", done, 0);
    repeat (3) @(negedge clk);
    chk("R9 results held", cfg_word, held);

    // R10: start during a search is ignored
    kick(32'd24000000, 12'd24, 32'd1000000000);
    repeat (10) @(negedge clk);
    parent_hz = 32'd400000000; parent_mhz = 12'd400; target_hz = 32'd5000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(lat);
    check_result("R10 ignored start", 24000000, 24, 1000000000);

    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule